// File: doc/BRIEF.md
# Two-Level Cache Lookup Sequencer

This block runs one read lookup at a time across two tag stores: a small upper-level store with a short fixed latency and a larger lower-level store with a longer one. It reports whether the address was found in the upper level, in the lower level or in neither. It also reports how many cycles the decision took. Data movement, line fill and victim selection are handled elsewhere. Both tag stores are modelled inside the block as direct-mapped arrays with a write port and a fixed-depth lookup pipeline.

A per-request mode bit chooses how the lower level is used. In serial mode the lower store is probed only after the upper store has answered with a miss. In parallel mode the lower store is probed in the same cycle as the upper one. This resolves misses in the upper level sooner, at the cost of a lower-level tag probe for every request. A free-running counter of lower-level probes makes that extra tag load visible. The default pipeline latencies are 2 cycles (upper) and 4 cycles (lower), and the lower latency must exceed the upper one.

Top module: `lookup_seq`

## Requirements
- R1: After reset, reqReady is 1, resValid is 0, lowerLookups is 0 and both tag stores hold no valid entry.
- R2: A request is accepted on a rising edge where reqValid and reqReady are both 1. From the next cycle reqReady stays 0 until the cycle in which resValid is 1, where it is 1 again. Only one request is ever in flight.
- R3: resValid is a single-cycle pulse. While it is 1, resCode is 2'b00 for a miss in both levels, 2'b01 for an upper-level hit and 2'b10 for a lower-level hit (with an upper miss). The value 2'b11 never appears.
- R4: An upper-level hit resolves in either mode with resValid high in the cycle after the 2nd rising edge following acceptance, and resLatency equal to 2.
- R5: In serial mode (reqParallel = 0 at acceptance), an upper miss starts the lower probe only after the upper answer arrives. The result (2'b10 or 2'b00) is due after the 6th edge following acceptance, with resLatency equal to 6.
- R6: In parallel mode (reqParallel = 1 at acceptance), an upper miss resolves after the 4th edge following acceptance, with resLatency equal to 4.
- R7: In parallel mode, the lower-level answer for a request that hit in the upper level is discarded. The result stays 2'b01 at latency 2, and a request accepted right after it is unaffected.
- R8: lowerLookups adds 1 for every lower-level probe. That is every accepted request in parallel mode, and only upper-level misses in serial mode.
- R9: reqParallel is sampled only at acceptance. Changing it while a lookup is in flight does not change that lookup's latency or result.
- R10: A write with instValid = 1 marks valid the entry of the upper store (instLower = 0) or the lower store (instLower = 1) at index instAddr[IW-1:0] and stores tag instAddr[AW-1:IW]. IW is 3 for the upper store and 5 for the lower one. A lookup hits a level only if that entry is valid and its tag equals the address's upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqAddr | input | AW | Address to look up |
| reqParallel | input | 1 | Mode for this request: 1 parallel, 0 serial |
| instValid | input | 1 | Write a tag entry |
| instLower | input | 1 | Target of the write: 1 lower store, 0 upper store |
| instAddr | input | AW | Address whose index and tag are written |
| resValid | output | 1 | One-cycle result strobe |
| resCode | output | 2 | Where the address was found |
| resLatency | output | clog2(UP_LAT+LO_LAT+2) | Cycles from acceptance to decision |
| lowerLookups | output | CNT_W | Count of lower-level probes |

## Verification
Results are due a fixed number of rising edges after the accepting edge: 2 for an upper hit, 4 for a parallel-mode upper miss and 6 for a serial-mode upper miss. The bench counts edges from acceptance, reads resValid at each following falling edge, and requires the first high sample to fall exactly on the expected count. While counting, it checks that reqReady stays low. It also reads the code, the latency field and the probe counter in the result cycle, and checks one cycle later that the pulse has ended.

// File: rtl/lookup_seq_pkg.sv
package lookup_seq_pkg;

  typedef enum logic [1:0] {
    RES_MISS  = 2'b00,
    RES_UPPER = 2'b01,
    RES_LOWER = 2'b10
  } resCode_e;

  // Per-cycle commands from the controller to the datapath.
  typedef struct packed {
    logic upStart;    // launch an upper-level probe with reqAddr
    logic loStart;    // launch a lower-level probe
    logic loFromReq;  // lower probe uses reqAddr rather than the held address
    logic latchReq;   // capture reqAddr for a later serial lower probe
    logic loFlush;    // drop any lower probe still in flight
  } strobes_t;

endpackage

// File: rtl/lookup_seq_tags.sv
module lookup_seq_tags #(
  parameter int AW   = 12,
  parameter int SETS = 8,
  parameter int LAT  = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          instValid,
  input  logic [AW-1:0] instAddr,
  input  logic          lookValid,
  input  logic [AW-1:0] lookAddr,
  input  logic          flush,
  output logic          doneValid,
  output logic          doneHit
);

  localparam int IW = $clog2(SETS);
  localparam int TW = AW - IW;

  logic [SETS-1:0] entValid;
  logic [TW-1:0]   entTag [SETS];

  logic [IW-1:0] instIdx, lookIdx;
  logic [TW-1:0] instTag, lookTag;
  logic          lookHit;

  assign instIdx = instAddr[IW-1:0];
  assign instTag = instAddr[AW-1:IW];
  assign lookIdx = lookAddr[IW-1:0];
  assign lookTag = lookAddr[AW-1:IW];
  assign lookHit = entValid[lookIdx] && (entTag[lookIdx] == lookTag);

  always_ff @(posedge clk) begin
    if (!rstN) entValid <= '0;
    else if (instValid) entValid[instIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (instValid) entTag[instIdx] <= instTag;
  end

  // Fixed-depth probe pipeline: the hit is decided at launch, delivered LAT edges later.
  logic [LAT-1:0] pipeValid, pipeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeValid <= '0;
      pipeHit   <= '0;
    end else begin
      pipeValid[0] <= lookValid;
      pipeHit[0]   <= lookHit;
      for (int i = 1; i < LAT; i++) begin
        pipeValid[i] <= pipeValid[i-1] && !flush;
        pipeHit[i]   <= pipeHit[i-1];
      end
    end
  end

  assign doneValid = pipeValid[LAT-1];
  assign doneHit   = pipeHit[LAT-1];

endmodule

// File: rtl/lookup_seq_datapath.sv
module lookup_seq_datapath
  import lookup_seq_pkg::*;
#(
  parameter int AW      = 12,
  parameter int UP_SETS = 8,
  parameter int LO_SETS = 32,
  parameter int UP_LAT  = 2,
  parameter int LO_LAT  = 4,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  logic [AW-1:0]    reqAddr,
  input  logic             instValid,
  input  logic             instLower,
  input  logic [AW-1:0]    instAddr,
  output logic             upDone,
  output logic             upHit,
  output logic             loDone,
  output logic             loHit,
  output logic [CNT_W-1:0] lowerLookups
);

  logic [AW-1:0] heldAddr;
  logic [AW-1:0] loAddr;

  always_ff @(posedge clk) begin
    if (!rstN) heldAddr <= '0;
    else if (strobes.latchReq) heldAddr <= reqAddr;
  end

  assign loAddr = strobes.loFromReq ? reqAddr : heldAddr;

  lookup_seq_tags #(.AW(AW), .SETS(UP_SETS), .LAT(UP_LAT)) u_upper (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid && !instLower),
    .instAddr  (instAddr),
    .lookValid (strobes.upStart),
    .lookAddr  (reqAddr),
    .flush     (1'b0),
    .doneValid (upDone),
    .doneHit   (upHit)
  );

  lookup_seq_tags #(.AW(AW), .SETS(LO_SETS), .LAT(LO_LAT)) u_lower (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid && instLower),
    .instAddr  (instAddr),
    .lookValid (strobes.loStart),
    .lookAddr  (loAddr),
    .flush     (strobes.loFlush),
    .doneValid (loDone),
    .doneHit   (loHit)
  );

  always_ff @(posedge clk) begin
    if (!rstN) lowerLookups <= '0;
    else if (strobes.loStart) lowerLookups <= lowerLookups + 1'b1;
  end

endmodule

// File: rtl/lookup_seq_ctrl.sv
module lookup_seq_ctrl
  import lookup_seq_pkg::*;
#(
  parameter int UP_LAT = 2,
  parameter int LO_LAT = 4,
  parameter int LAT_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqParallel,
  output logic             reqReady,
  input  logic             upDone,
  input  logic             upHit,
  input  logic             loDone,
  input  logic             loHit,
  output strobes_t         strobes,
  output logic             resValid,
  output logic [1:0]       resCode,
  output logic [LAT_W-1:0] resLatency
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT_UP, S_WAIT_LO} state_e;

  state_e           state;
  logic             modeHeld;
  logic [LAT_W-1:0] cyc;
  resCode_e         codeReg;
  logic             accept;

  assign reqReady = (state == S_IDLE);
  assign accept   = reqValid && reqReady;
  assign resCode  = codeReg;

  always_comb begin
    strobes = '0;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          strobes.upStart  = 1'b1;
          strobes.latchReq = 1'b1;
          if (reqParallel) begin
            strobes.loStart   = 1'b1;
            strobes.loFromReq = 1'b1;
          end
        end
      end
      S_WAIT_UP: begin
        if (upDone) begin
          if (upHit) strobes.loFlush = modeHeld;
          else if (!modeHeld) strobes.loStart = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      modeHeld   <= 1'b0;
      cyc        <= '0;
      resValid   <= 1'b0;
      codeReg    <= RES_MISS;
      resLatency <= '0;
    end else begin
      resValid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            state    <= S_WAIT_UP;
            modeHeld <= reqParallel;
            cyc      <= LAT_W'(1);
          end
        end
        S_WAIT_UP: begin
          cyc <= cyc + 1'b1;
          if (upDone) begin
            if (upHit) begin
              resValid   <= 1'b1;
              codeReg    <= RES_UPPER;
              resLatency <= cyc;
              state      <= S_IDLE;
            end else begin
              state <= S_WAIT_LO;
            end
          end
        end
        S_WAIT_LO: begin
          cyc <= cyc + 1'b1;
          if (loDone) begin
            resValid   <= 1'b1;
            codeReg    <= loHit ? RES_LOWER : RES_MISS;
            resLatency <= cyc;
            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lookup_seq.sv
module lookup_seq
  import lookup_seq_pkg::*;
#(
  parameter int AW      = 12,
  parameter int UP_SETS = 8,
  parameter int LO_SETS = 32,
  parameter int UP_LAT  = 2,
  parameter int LO_LAT  = 4,
  parameter int CNT_W   = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  reqValid,
  output logic                                  reqReady,
  input  logic [AW-1:0]                         reqAddr,
  input  logic                                  reqParallel,
  input  logic                                  instValid,
  input  logic                                  instLower,
  input  logic [AW-1:0]                         instAddr,
  output logic                                  resValid,
  output logic [1:0]                            resCode,
  output logic [$clog2(UP_LAT+LO_LAT+2)-1:0]    resLatency,
  output logic [CNT_W-1:0]                      lowerLookups
);

  localparam int LAT_W = $clog2(UP_LAT + LO_LAT + 2);

  strobes_t strobes;
  logic     upDone, upHit, loDone, loHit;

  lookup_seq_ctrl #(.UP_LAT(UP_LAT), .LO_LAT(LO_LAT), .LAT_W(LAT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqParallel (reqParallel),
    .reqReady    (reqReady),
    .upDone      (upDone),
    .upHit       (upHit),
    .loDone      (loDone),
    .loHit       (loHit),
    .strobes     (strobes),
    .resValid    (resValid),
    .resCode     (resCode),
    .resLatency  (resLatency)
  );

  lookup_seq_datapath #(
    .AW(AW), .UP_SETS(UP_SETS), .LO_SETS(LO_SETS),
    .UP_LAT(UP_LAT), .LO_LAT(LO_LAT), .CNT_W(CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .reqAddr      (reqAddr),
    .instValid    (instValid),
    .instLower    (instLower),
    .instAddr     (instAddr),
    .upDone       (upDone),
    .upHit        (upHit),
    .loDone       (loDone),
    .loHit        (loHit),
    .lowerLookups (lowerLookups)
  );

endmodule

// File: rtl/lookup_seq_chk.sv
module lookup_seq_chk #(
  parameter int UP_LAT = 2,
  parameter int LO_LAT = 4,
  parameter int CNT_W  = 16,
  parameter int LAT_W  = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqParallel,
  input logic             resValid,
  input logic [1:0]       resCode,
  input logic [LAT_W-1:0] resLatency,
  input logic [CNT_W-1:0] lowerLookups
);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r2_ready_with_result: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> reqReady);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (resCode != 2'b11));

  a_r4_upper_latency: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resCode == 2'b01) |-> (resLatency == LAT_W'(UP_LAT)));

  a_r5_lower_latency: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resCode != 2'b01) |->
      (resLatency == LAT_W'(LO_LAT) || resLatency == LAT_W'(UP_LAT + LO_LAT)));

  a_r8_parallel_counts: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqParallel) |=>
      (lowerLookups == $past(lowerLookups) + 1'b1));

endmodule

bind lookup_seq lookup_seq_chk #(
  .UP_LAT(UP_LAT), .LO_LAT(LO_LAT), .CNT_W(CNT_W),
  .LAT_W($clog2(UP_LAT + LO_LAT + 2))
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqParallel  (reqParallel),
  .resValid     (resValid),
  .resCode      (resCode),
  .resLatency   (resLatency),
  .lowerLookups (lowerLookups)
);

// File: tb/lookup_seq_tb.sv
module lookup_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int CNT_W = 16;
  localparam int LAT_W = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [AW-1:0]    reqAddr = '0;
  logic             reqParallel = 1'b0;
  logic             instValid = 1'b0;
  logic             instLower = 1'b0;
  logic [AW-1:0]    instAddr = '0;
  logic             resValid;
  logic [1:0]       resCode;
  logic [LAT_W-1:0] resLatency;
  logic [CNT_W-1:0] lowerLookups;

  int checks = 0;
  int errors = 0;
  int expCount = 0;
  bit done = 1'b0;

  bit       upV [8];
  bit [8:0] upT [8];
  bit       loV [32];
  bit [6:0] loT [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  lookup_seq u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqParallel(reqParallel),
    .instValid(instValid), .instLower(instLower), .instAddr(instAddr),
    .resValid(resValid), .resCode(resCode), .resLatency(resLatency),
    .lowerLookups(lowerLookups)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int modelCode(input logic [AW-1:0] a);
    if (upV[a[2:0]] && upT[a[2:0]] == a[11:3]) return 1;
    if (loV[a[4:0]] && loT[a[4:0]] == a[11:5]) return 2;
    return 0;
  endfunction

  function automatic int modelLat(input int code, input bit par);
    if (code == 1) return 2;
    return par ? 4 : 6;
  endfunction

  task automatic install(input bit lower, input logic [AW-1:0] a);
    @(negedge clk);
    instValid = 1'b1;
    instLower = lower;
    instAddr  = a;
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0;
    if (lower) begin loV[a[4:0]] = 1'b1; loT[a[4:0]] = a[11:5]; end
    else       begin upV[a[2:0]] = 1'b1; upT[a[2:0]] = a[11:3]; end
  endtask

  task automatic lookup(input logic [AW-1:0] a, input bit par, input bit flip, input string tag);
    int code, lat, k;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    code = modelCode(a);
    lat  = modelLat(code, par);
    if (par || code != 1) expCount++;
    reqValid    = 1'b1;
    reqAddr     = a;
    reqParallel = par;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (flip) reqParallel = !par;
    chk(reqReady == 1'b0, "R2 ready low after accept", reqReady, 0);
    k = 0;
    while (k < 20) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (resValid) break;
    end
    chk(k == lat, {tag, " result edge"}, k, lat);
    chk(int'(resCode) == code, {tag, " R3 code"}, resCode, code);
    chk(int'(resLatency) == lat, {tag, " latency field"}, resLatency, lat);
    chk(reqReady == 1'b1, "R2 ready with result", reqReady, 1);
    chk(int'(lowerLookups) == expCount, "R8 lower probe count", lowerLookups, expCount);
    if (flip) chk(k == lat, "R9 mode change ignored", k, lat);
    @(posedge clk);
    @(negedge clk);
    chk(resValid == 1'b0, "R3 pulse one cycle", resValid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    chk(resValid == 1'b0, "R1 no result after reset", resValid, 0);
    chk(lowerLookups == '0, "R1 counter zero", lowerLookups, 0);

    // Empty stores: misses in both modes.
    lookup(12'h013, 1'b0, 1'b0, "R1 R5 empty serial");
    lookup(12'h013, 1'b1, 1'b0, "R1 R6 empty parallel");

    // Lower-only hit.
    install(1'b1, 12'h013);
    lookup(12'h013, 1'b0, 1'b0, "R5 serial lower hit");
    lookup(12'h013, 1'b1, 1'b0, "R6 parallel lower hit");

    // Upper hit in both modes, then a back-to-back parallel miss.
    install(1'b0, 12'h013);
    lookup(12'h013, 1'b0, 1'b0, "R4 serial upper hit");
    lookup(12'h013, 1'b1, 1'b0, "R4 R7 parallel upper hit");
    lookup(12'h2C6, 1'b1, 1'b0, "R7 parallel follow-up miss");

    // Mode changed mid-lookup.
    install(1'b1, 12'h0E4);
    lookup(12'h0E4, 1'b0, 1'b1, "R9 serial then flipped");
    lookup(12'h0E4, 1'b1, 1'b1, "R9 parallel then flipped");

    // Same index, different tag: no hit.
    install(1'b0, 12'h0A5);
    lookup(12'h0AD, 1'b0, 1'b0, "R10 tag mismatch");
    lookup(12'h0A5, 1'b0, 1'b0, "R10 tag match");

    // Random mix of writes and lookups over a narrow address range.
    for (int i = 0; i < 200; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) install(1'($urandom_range(0, 1)), a);
      else lookup(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R10 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule